// File: doc/BRIEF.md
# Multi-Level Trigger Sequencer

This block decides when a logic-analyzer capture fires. It walks through up to eight programmed levels. At each level it looks at up to four ordered branch clauses. Each clause picks one bit out of a condition vector, and may invert it. The vector holds precomputed pattern and range match bits, together with internal status from a global timer, two event counters and four flags. On each clock the first clause that matches runs its action. The action can move to another level, fire the trigger, stop the sequencer and request memory fill, or clear the level's occurrence counter. The same clause may also change any flag.

Software loads the per-level clauses, the per-level occurrence targets and the timer and event-counter limits through a simple register write port. A synchronous start input begins a new run and keeps the programming. A trigger takes effect only while the arm input is high, and only one trigger is accepted per run.

Top module: `trig_seq`

## Requirements
- R1: After reset, and one cycle after start is sampled high, the level is 0, trigPulse and fillReq are low, flags are 0000, and the occurrence counters, the timer and the event counters are cleared. Programming is kept across start. While start is high no clause is evaluated.
- R2: Clause 0 has the highest priority and clause 3 the lowest. Only the first enabled clause whose condition is true acts in a cycle. A clause with its enable bit clear never acts.
- R3: Each level has an occurrence counter. It advances in every cycle in which clause 0 of the current level is enabled and its condition is true. Clause 0 matches only when this count, including the current cycle, reaches the level's target. A target of 0 or 1 matches on the first occurrence.
- R4: A goto to a different level clears the destination level's counter. A goto to the current level keeps that level's count.
- R5: Action 3 (counter reset) clears the current level's counter and leaves the level unchanged. The clear wins over an increment in the same cycle.
- R6: A trigger action has an effect only while armIn is high. If armIn is low, action 1 still performs its goto, and action 2 does nothing.
- R7: An accepted trigger raises trigPulse for exactly one cycle, in the cycle after the matching sample. Every later trigger action in the same run is ignored until start.
- R8: Action 2, when accepted, pulses the trigger and sets fillReq, which stays high until start. While fillReq is high the level no longer changes. Action 1 never sets fillReq. Action 0 is a plain goto.
- R9: Each clause carries a 3-bit operation per flag: 0 none, 1 set, 2 clear, 3 pulse-set (high for one cycle, then back to the held value), 4 pulse-clear (low for one cycle, then back). The flags output shows the result one cycle after the match.
- R10: The timer counts clock cycles from start and stops at its limit. Its done bit is true while count >= limit. With limit L and a clause that tests the timer bit, the goto is seen L+1 cycles after the start cycle.
- R11: Event counter k counts cycles with evtIn[k] high, stops at its limit, and reports done while count >= limit.
- R12: Condition select index: 0..COND_W-1 are condIn bits, COND_W is the timer done bit, COND_W+1 and COND_W+2 are the event counter done bits, COND_W+3..COND_W+6 are flags 0..3, and COND_W+7 is constant 1. The invert bit complements the selected bit.
- R13: Write map. Address bit 6 clear selects level = addr[5:3] and slot = addr[2:0]. Slots 0..3 hold clauses, with en in bit 0, invert in bit 1, select in [6:2], action in [8:7], goto target in [11:9], and flag f's operation in [14+3f:12+3f]. Slot 4 holds the occurrence target. Addresses 64, 65 and 66 hold the timer limit and the limits of event counters 0 and 1. Reset clears all programming.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin a new run (clears run state, keeps programming) |
| armIn | input | 1 | Allows trigger actions while high |
| condIn | input | COND_W | Precomputed pattern/range condition bits |
| evtIn | input | 2 | Event inputs for the two event counters |
| cfgWe | input | 1 | Programming write strobe |
| cfgAddr | input | 7 | Programming address |
| cfgData | input | 32 | Programming data |
| trigPulse | output | 1 | One-cycle trigger pulse |
| fillReq | output | 1 | Latched request to fill sample memory |
| level | output | 3 | Current sequencer level |
| flags | output | 4 | Flag values including pulses |

## Verification
The bench aims at the counter edges. It checks that the target is reached on exactly the Nth occurrence, that re-entering a level restarts its count while a self-goto keeps it, and that a counter-reset clause beats the increment. A wrong design here would fire one occurrence early or late, or carry stale counts across levels. It also checks that an unarmed trigger clause still moves the level but does not pulse, that a second trigger in one run is dropped, and that the level freezes after a fill request. Missing gating would show extra trigPulse cycles or level changes after the fill. Flag pulses are checked for their one-cycle width and their return to the held value. The timer and event counters are checked against the exact cycle at which their done bits steer a goto, so an off-by-one in the limit compare shows up as a wrong level.

// File: rtl/trig_seq_pkg.sv
package trig_seq_pkg;

  localparam int LVL_W   = 3;
  localparam int BR_N    = 4;
  localparam int BR_W    = 2;
  localparam int FLAG_N  = 4;
  localparam int SEL_W   = 5;
  localparam int FOP_W   = 3;

  typedef enum logic [1:0] {
    ACT_GOTO      = 2'd0,
    ACT_TRIG_GOTO = 2'd1,
    ACT_TRIG_FILL = 2'd2,
    ACT_OCC_RST   = 2'd3
  } act_e;

  typedef enum logic [FOP_W-1:0] {
    FOP_NONE = 3'd0,
    FOP_SET  = 3'd1,
    FOP_CLR  = 3'd2,
    FOP_PSET = 3'd3,
    FOP_PCLR = 3'd4
  } fop_e;

  // packed: first member is the most significant field
  typedef struct packed {
    logic [FLAG_N*FOP_W-1:0] fops;
    logic [LVL_W-1:0]        target;
    act_e                    act;
    logic [SEL_W-1:0]        sel;
    logic                    inv;
    logic                    en;
  } branch_t;

  typedef struct packed {
    logic              restart;
    logic              occInc;
    logic              occClrCur;
    logic              occClrNew;
    logic [LVL_W-1:0]  newLevel;
    logic [FLAG_N-1:0] fSet;
    logic [FLAG_N-1:0] fClr;
    logic [FLAG_N-1:0] fPSet;
    logic [FLAG_N-1:0] fPClr;
  } strobe_t;

endpackage

// File: rtl/trig_seq_dp.sv
module trig_seq_dp
  import trig_seq_pkg::*;
#(
  parameter int COND_W = 8,
  parameter int OCC_W  = 30,
  parameter int TMR_W  = 32,
  parameter int EVC_W  = 16,
  parameter int CFG_AW = 7,
  parameter int CFG_DW = 32
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfgWe,
  input  logic [CFG_AW-1:0]        cfgAddr,
  input  logic [CFG_DW-1:0]        cfgData,
  input  logic [COND_W-1:0]        condIn,
  input  logic [1:0]               evtIn,
  input  logic [LVL_W-1:0]         curLevel,
  input  strobe_t                  strb,
  output branch_t [BR_N-1:0]       curBranches,
  output logic [OCC_W-1:0]         occCount,
  output logic [OCC_W-1:0]         occTarget,
  output logic [(1<<SEL_W)-1:0]    condVec,
  output logic [FLAG_N-1:0]        flagsOut
);

  localparam int NUM_LEVELS = 1 << LVL_W;
  localparam int BR_BITS    = $bits(branch_t);
  localparam int TMR_IDX    = COND_W;
  localparam int EVC_IDX    = COND_W + 1;
  localparam int FLG_IDX    = COND_W + 3;
  localparam int ONE_IDX    = COND_W + 3 + FLAG_N;
  localparam int EVC_N      = 2;

  // programming storage
  branch_t          brMem  [NUM_LEVELS][BR_N];
  logic [OCC_W-1:0] tgtMem [NUM_LEVELS];
  logic [TMR_W-1:0] tmrLimit;
  logic [EVC_W-1:0] evcLimit [EVC_N];

  logic              cfgGlobal;
  logic [LVL_W-1:0]  cfgLvl;
  logic [2:0]        cfgSlot;

  assign cfgGlobal = cfgAddr[CFG_AW-1];
  assign cfgLvl    = cfgAddr[CFG_AW-2 -: LVL_W];
  assign cfgSlot   = cfgAddr[2:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int l = 0; l < NUM_LEVELS; l++) begin
        tgtMem[l] <= '0;
        for (int b = 0; b < BR_N; b++) brMem[l][b] <= '0;
      end
      tmrLimit <= '0;
      for (int k = 0; k < EVC_N; k++) evcLimit[k] <= '0;
    end else if (cfgWe) begin
      if (!cfgGlobal) begin
        if (cfgSlot < 3'(BR_N))
          brMem[cfgLvl][cfgSlot[BR_W-1:0]] <= branch_t'(cfgData[BR_BITS-1:0]);
        else if (cfgSlot == 3'(BR_N))
          tgtMem[cfgLvl] <= cfgData[OCC_W-1:0];
      end else begin
        case (cfgAddr[1:0])
          2'd0: tmrLimit    <= cfgData[TMR_W-1:0];
          2'd1: evcLimit[0] <= cfgData[EVC_W-1:0];
          2'd2: evcLimit[1] <= cfgData[EVC_W-1:0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    for (int b = 0; b < BR_N; b++) curBranches[b] = brMem[curLevel][b];
  end
  assign occTarget = tgtMem[curLevel];

  // per-level occurrence counters
  logic [NUM_LEVELS-1:0][OCC_W-1:0] occAll;

  for (genvar l = 0; l < NUM_LEVELS; l++) begin : g_occ
    logic [OCC_W-1:0] cnt;
    logic isCur, isNew;
    assign isCur = (curLevel == LVL_W'(l));
    assign isNew = (strb.newLevel == LVL_W'(l));
    always_ff @(posedge clk) begin
      if (rst || strb.restart)
        cnt <= '0;
      else if ((strb.occClrNew && isNew) || (strb.occClrCur && isCur))
        cnt <= '0;
      else if (strb.occInc && isCur && (cnt != '1))
        cnt <= cnt + 1'b1;
    end
    assign occAll[l] = cnt;
  end

  assign occCount = occAll[curLevel];

  // global timer
  logic [TMR_W-1:0] tmrCnt;
  logic             tmrDone;
  always_ff @(posedge clk) begin
    if (rst || strb.restart)      tmrCnt <= '0;
    else if (tmrCnt < tmrLimit)   tmrCnt <= tmrCnt + 1'b1;
  end
  assign tmrDone = (tmrCnt >= tmrLimit);

  // event counters
  logic [EVC_N-1:0] evcDone;
  for (genvar k = 0; k < EVC_N; k++) begin : g_evc
    logic [EVC_W-1:0] cnt;
    always_ff @(posedge clk) begin
      if (rst || strb.restart)                cnt <= '0;
      else if (evtIn[k] && (cnt < evcLimit[k])) cnt <= cnt + 1'b1;
    end
    assign evcDone[k] = (cnt >= evcLimit[k]);
  end

  // flags with one-cycle pulse overlays
  logic [FLAG_N-1:0] flagBase, pSetR, pClrR;
  always_ff @(posedge clk) begin
    if (rst || strb.restart) begin
      flagBase <= '0;
      pSetR    <= '0;
      pClrR    <= '0;
    end else begin
      flagBase <= (flagBase | strb.fSet) & ~strb.fClr;
      pSetR    <= strb.fPSet;
      pClrR    <= strb.fPClr;
    end
  end
  assign flagsOut = (flagBase | pSetR) & ~pClrR;

  always_comb begin
    condVec                      = '0;
    condVec[COND_W-1:0]          = condIn;
    condVec[TMR_IDX]             = tmrDone;
    condVec[EVC_IDX +: EVC_N]    = evcDone;
    condVec[FLG_IDX +: FLAG_N]   = flagsOut;
    condVec[ONE_IDX]             = 1'b1;
  end

endmodule

// File: rtl/trig_seq_ctrl.sv
module trig_seq_ctrl
  import trig_seq_pkg::*;
#(
  parameter int OCC_W = 30
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic                   armIn,
  input  branch_t [BR_N-1:0]     curBranches,
  input  logic [OCC_W-1:0]       occCount,
  input  logic [OCC_W-1:0]       occTarget,
  input  logic [(1<<SEL_W)-1:0]  condVec,
  output logic [LVL_W-1:0]       level,
  output logic                   trigPulse,
  output logic                   fillReq,
  output strobe_t                strb
);

  logic              triggered;
  logic [BR_N-1:0]   hit, match;
  logic              occReached, active, accept, found;
  logic [BR_W-1:0]   pick;
  branch_t           chosen;
  logic [LVL_W-1:0]  nextLevel;
  logic              doTrig, doFill;

  assign occReached = ((OCC_W+1)'(occCount) + 1'b1) >= (OCC_W+1)'(occTarget);
  assign active     = !start && !fillReq;
  assign accept     = armIn && !triggered;

  always_comb begin
    for (int b = 0; b < BR_N; b++) begin
      hit[b]   = curBranches[b].en && (condVec[curBranches[b].sel] ^ curBranches[b].inv);
      match[b] = hit[b];
    end
    match[0] = hit[0] && occReached;
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int b = 0; b < BR_N; b++) begin
      if (!found && match[b]) begin
        found = 1'b1;
        pick  = BR_W'(b);
      end
    end
  end

  assign chosen = curBranches[pick];

  always_comb begin
    strb         = '0;
    strb.restart = start;
    nextLevel    = level;
    doTrig       = 1'b0;
    doFill       = 1'b0;
    if (active) begin
      strb.occInc = hit[0];
      if (found) begin
        case (chosen.act)
          ACT_GOTO: begin
            nextLevel      = chosen.target;
            strb.occClrNew = (chosen.target != level);
          end
          ACT_TRIG_GOTO: begin
            nextLevel      = chosen.target;
            strb.occClrNew = (chosen.target != level);
            doTrig         = accept;
          end
          ACT_TRIG_FILL: begin
            doTrig = accept;
            doFill = accept;
          end
          default: strb.occClrCur = 1'b1;
        endcase
        for (int f = 0; f < FLAG_N; f++) begin
          case (fop_e'(chosen.fops[f*FOP_W +: FOP_W]))
            FOP_SET:  strb.fSet[f]  = 1'b1;
            FOP_CLR:  strb.fClr[f]  = 1'b1;
            FOP_PSET: strb.fPSet[f] = 1'b1;
            FOP_PCLR: strb.fPClr[f] = 1'b1;
            default:  ;
          endcase
        end
      end
    end
    strb.newLevel = nextLevel;
  end

  always_ff @(posedge clk) begin
    if (rst || start) begin
      level     <= '0;
      trigPulse <= 1'b0;
      triggered <= 1'b0;
      fillReq   <= 1'b0;
    end else begin
      level     <= nextLevel;
      trigPulse <= doTrig;
      if (doTrig) triggered <= 1'b1;
      if (doFill) fillReq   <= 1'b1;
    end
  end

endmodule

// File: rtl/trig_seq.sv
module trig_seq
  import trig_seq_pkg::*;
#(
  parameter int COND_W = 8,
  parameter int OCC_W  = 30,
  parameter int TMR_W  = 32,
  parameter int EVC_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              armIn,
  input  logic [COND_W-1:0] condIn,
  input  logic [1:0]        evtIn,
  input  logic              cfgWe,
  input  logic [6:0]        cfgAddr,
  input  logic [31:0]       cfgData,
  output logic              trigPulse,
  output logic              fillReq,
  output logic [2:0]        level,
  output logic [3:0]        flags
);

  localparam int CFG_AW = LVL_W + 4;
  localparam int CFG_DW = 32;

  strobe_t                  strb;
  branch_t [BR_N-1:0]       curBranches;
  logic [OCC_W-1:0]         occCount, occTarget;
  logic [(1<<SEL_W)-1:0]    condVec;

  trig_seq_ctrl #(.OCC_W(OCC_W)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .armIn(armIn),
    .curBranches(curBranches), .occCount(occCount), .occTarget(occTarget),
    .condVec(condVec), .level(level), .trigPulse(trigPulse),
    .fillReq(fillReq), .strb(strb)
  );

  trig_seq_dp #(
    .COND_W(COND_W), .OCC_W(OCC_W), .TMR_W(TMR_W), .EVC_W(EVC_W),
    .CFG_AW(CFG_AW), .CFG_DW(CFG_DW)
  ) u_dp (
    .clk(clk), .rst(rst), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .condIn(condIn), .evtIn(evtIn), .curLevel(level), .strb(strb),
    .curBranches(curBranches), .occCount(occCount), .occTarget(occTarget),
    .condVec(condVec), .flagsOut(flags)
  );

endmodule

// File: rtl/trig_seq_chk.sv
module trig_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       start,
  input logic       armIn,
  input logic       trigPulse,
  input logic       fillReq,
  input logic [2:0] level,
  input logic [3:0] flags
);

  // R1
  restart_clears_chk: assert property (@(posedge clk) disable iff (rst)
    start |=> (level == 3'd0 && !fillReq && !trigPulse && flags == 4'd0));

  // R6
  trig_needs_arm_chk: assert property (@(posedge clk) disable iff (rst)
    trigPulse |-> $past(armIn));

  // R7
  trig_single_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    trigPulse && !start |=> !trigPulse);

  // R8
  fill_holds_chk: assert property (@(posedge clk) disable iff (rst)
    fillReq && !start |=> fillReq);

  // R8
  fill_freezes_level_chk: assert property (@(posedge clk) disable iff (rst)
    fillReq && !start |=> $stable(level));

  // R8
  fill_with_trig_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fillReq) |-> trigPulse);

endmodule

bind trig_seq trig_seq_chk u_chk (
  .clk(clk), .rst(rst), .start(start), .armIn(armIn),
  .trigPulse(trigPulse), .fillReq(fillReq), .level(level), .flags(flags)
);

// File: tb/tb_trig_seq.sv
module tb_trig_seq;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start = 1'b0;
  logic       armIn = 1'b0;
  logic [7:0] condIn = '0;
  logic [1:0] evtIn = '0;
  logic       cfgWe = 1'b0;
  logic [6:0] cfgAddr = '0;
  logic [31:0] cfgData = '0;
  logic       trigPulse, fillReq;
  logic [2:0] level;
  logic [3:0] flags;

  int nChk = 0;
  int nFail = 0;
  int cyc = 0;

  always #10 clk = ~clk;

  trig_seq dut (
    .clk(clk), .rst(rst), .start(start), .armIn(armIn), .condIn(condIn),
    .evtIn(evtIn), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .trigPulse(trigPulse), .fillReq(fillReq), .level(level), .flags(flags)
  );

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      nFail++;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
      $finish;
    end
  end

  // codes stated in R12/R13
  localparam int GOTO = 0, TGOTO = 1, TFILL = 2, ORST = 3;
  localparam int SET = 1, CLR = 2, PSET = 3, PCLR = 4;
  localparam int S_TMR = 8, S_EVC0 = 9, S_FLG0 = 11, S_ONE = 15;

  function automatic logic [31:0] br(int sel, int inv, int act, int tgt, int fops);
    return {8'h0, 12'(fops), 3'(tgt), 2'(act), 5'(sel), 1'(inv), 1'b1};
  endfunction

  function automatic int fop(int f, int op);
    return op << (3 * f);
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, int act, int exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(int addr, logic [31:0] data);
    cfgWe = 1'b1; cfgAddr = 7'(addr); cfgData = data;
    step();
    cfgWe = 1'b0;
  endtask

  task automatic doReset();
    rst = 1'b1; start = 1'b0; armIn = 1'b0; condIn = '0; evtIn = '0;
    step(); step();
    rst = 1'b0;
  endtask

  task automatic restart();
    start = 1'b1; step(); start = 1'b0;
  endtask

  task automatic t_reset();
    doReset();
    chk("R1 level", level, 0);
    chk("R1 trig", trigPulse, 0);
    chk("R1 fill", fillReq, 0);
    chk("R1 flags", flags, 0);
  endtask

  task automatic t_priority();
    doReset();
    wr(0, br(0, 0, GOTO, 1, 0));
    wr(1, br(1, 0, GOTO, 2, 0));
    wr(2, br(S_ONE, 0, GOTO, 5, 0) & 32'hFFFF_FFFE); // disabled
    step();
    chk("R2 disabled clause", level, 0);
    condIn = 8'h03; step();
    chk("R2 first clause wins", level, 1);
    condIn = 8'h00;
    restart();
    condIn = 8'h02; step();
    chk("R2 fall through", level, 2);
    condIn = 8'h00;
    wr(48, br(S_ONE, 0, GOTO, 7, 0));   // level 6 clause 0
    restart();
    wr(2, br(S_ONE, 0, GOTO, 6, 0));
    step();
    chk("R12 constant one goto", level, 6);
    step();
    chk("R13 level 6 write", level, 7);
  endtask

  task automatic t_occ();
    doReset();
    wr(4, 3);                            // R13 slot 4 target
    wr(0, br(0, 0, GOTO, 1, 0));
    for (int i = 0; i < 2; i++) begin
      condIn = 8'h01; step(); condIn = 8'h00; step();
    end
    chk("R3 below target", level, 0);
    condIn = 8'h01; step(); condIn = 8'h00;
    chk("R3 target reached", level, 1);
  endtask

  task automatic t_entry();
    doReset();
    wr(4, 2);
    wr(0, br(0, 0, GOTO, 1, 0));
    wr(1, br(3, 0, GOTO, 1, 0));
    wr(8, br(1, 0, GOTO, 0, 0));
    condIn = 8'h01; step();
    condIn = 8'h08; step();
    chk("R4 left level", level, 1);
    condIn = 8'h02; step();
    chk("R4 back", level, 0);
    condIn = 8'h01; step();
    chk("R4 entry cleared count", level, 0);
    step();
    chk("R4 second occurrence", level, 1);
    condIn = 8'h00;
    doReset();
    wr(4, 2);
    wr(0, br(0, 0, GOTO, 1, 0));
    wr(1, br(3, 0, GOTO, 0, 0));
    condIn = 8'h01; step();
    condIn = 8'h08; step();
    condIn = 8'h01; step();
    condIn = 8'h00;
    chk("R4 self goto keeps count", level, 1);
  endtask

  task automatic t_occrst();
    doReset();
    wr(4, 2);
    wr(0, br(0, 0, GOTO, 1, 0));
    wr(1, br(1, 0, ORST, 0, 0));
    condIn = 8'h01; step();
    condIn = 8'h02; step();
    condIn = 8'h01; step();
    chk("R5 counter reset", level, 0);
    step();
    condIn = 8'h00;
    chk("R5 count after reset", level, 1);
  endtask

  task automatic t_arm_fill();
    doReset();
    wr(0, br(0, 0, TFILL, 0, 0));
    wr(1, br(1, 0, GOTO, 4, 0));
    armIn = 1'b0; condIn = 8'h01; step();
    chk("R6 unarmed no trig", trigPulse, 0);
    chk("R6 unarmed no fill", fillReq, 0);
    armIn = 1'b1; step();
    chk("R7 trig pulse", trigPulse, 1);
    chk("R8 fill set", fillReq, 1);
    condIn = 8'h00; step();
    chk("R7 pulse one cycle", trigPulse, 0);
    chk("R8 fill held", fillReq, 1);
    condIn = 8'h02; step();
    chk("R8 halted level", level, 0);
    condIn = 8'h00;
  endtask

  task automatic t_once();
    doReset();
    wr(0, br(0, 0, TGOTO, 1, 0));
    wr(8, br(0, 0, TGOTO, 2, 0));
    armIn = 1'b0; condIn = 8'h01; step();
    chk("R6 unarmed goto moves", level, 1);
    chk("R6 unarmed goto no trig", trigPulse, 0);
    condIn = 8'h00; restart();
    armIn = 1'b1; condIn = 8'h01; step();
    chk("R7 first trig", trigPulse, 1);
    chk("R7 level", level, 1);
    step();
    chk("R7 second trig ignored", trigPulse, 0);
    chk("R7 goto still moves", level, 2);
    chk("R8 trig-goto no fill", fillReq, 0);
    restart();
    chk("R1 restart level", level, 0);
    step();
    chk("R1 restart rearms trig", trigPulse, 1);
    condIn = 8'h00; armIn = 1'b0;
  endtask

  task automatic t_flags();
    doReset();
    wr(0, br(0, 0, GOTO, 0, fop(0, SET) | fop(1, PSET)));
    wr(1, br(1, 0, GOTO, 0, fop(0, PCLR) | fop(2, SET)));
    wr(2, br(2, 0, GOTO, 0, fop(0, CLR)));
    condIn = 8'h01; step();
    chk("R9 set and pulse-set", flags, 4'b0011);
    condIn = 8'h00; step();
    chk("R9 pulse-set ends", flags, 4'b0001);
    condIn = 8'h02; step();
    chk("R9 pulse-clear", flags, 4'b0100);
    condIn = 8'h00; step();
    chk("R9 pulse-clear ends", flags, 4'b0101);
    condIn = 8'h04; step();
    chk("R9 clear", flags, 4'b0100);
    condIn = 8'h00;
    restart();
    chk("R1 restart clears flags", flags, 0);
  endtask

  task automatic t_cond();
    doReset();
    wr(0, br(S_FLG0, 0, GOTO, 3, 0));
    wr(1, br(1, 0, GOTO, 0, fop(0, SET)));
    condIn = 8'h02; step();
    chk("R12 flag set seen", level, 0);
    condIn = 8'h00; step();
    chk("R12 flag as condition", level, 3);
    doReset();
    wr(0, br(0, 1, GOTO, 1, 0));
    condIn = 8'h01; step();
    chk("R12 invert holds", level, 0);
    condIn = 8'h00; step();
    chk("R12 invert fires", level, 1);
  endtask

  task automatic t_timer();
    doReset();
    wr(64, 5);
    wr(0, br(S_TMR, 0, GOTO, 1, 0));
    restart();
    for (int i = 0; i < 5; i++) step();
    chk("R10 timer not yet", level, 0);
    step();
    chk("R10 timer done", level, 1);
  endtask

  task automatic t_evc();
    doReset();
    wr(65, 3);
    wr(0, br(S_EVC0, 0, GOTO, 2, 0));
    restart();
    evtIn = 2'b01;
    for (int i = 0; i < 3; i++) step();
    evtIn = 2'b00;
    chk("R11 event not yet", level, 0);
    step();
    chk("R11 event done", level, 2);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_priority();
    t_occ();
    t_entry();
    t_occrst();
    t_arm_fill();
    t_once();
    t_flags();
    t_cond();
    t_timer();
    t_evc();
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

endmodule